// File: doc/BRIEF.md
# Systolic FIR Convolution Array

This block computes a sliding one-dimensional convolution of a streamed sequence of signed samples with a short set of signed weights. It is a chain of identical cells. Samples enter the first cell and move to the next cell through two registers per cell. Partial sums start at zero in the first cell and move one cell per step. Because partial sums move twice as fast as samples, each running sum meets every sample of its window in turn. Every sample taken from the input is used by every cell before it drops off the end of the chain.

Each cell splits its work into two registered stages: a multiply and an add. A new product is formed while the previous one is being accumulated. Each cell stores one weight per bank. The caller chooses the bank per window with a select input that travels with the first sample of the window. Switching banks in the middle of a stream therefore never mixes banks within one output. Weights are written one at a time through a small write port while no sample is being offered.

The array advances only when a sample is accepted. The result register at the end of the chain is the output buffer. A stalled output holds the whole array in place.

Top module: `conv_array`

## Requirements
- R1: With weight set W[b] selected for window i, the output for that window equals the signed sum over m = 0..N_TAPS-1 of W[b][m]·x(i+m). x(k) is the k-th accepted sample, counted from 0 after reset. The sum is exact in two's complement at ACC_W = 32 + clog2(N_TAPS) bits, which is 34 bits for the default N_TAPS = 3.
- R2: After the fill, every accepted sample produces exactly one output. Outputs leave in window order 0, 1, 2, … with none lost or repeated.
- R3: out_valid stays low until 2·N_TAPS+1 samples have been accepted. Window i becomes visible in the cycle after sample i+2·N_TAPS is accepted.
- R4: A sample is accepted only while the output register is empty or is being taken in the same cycle (in_ready = !out_valid || out_ready). While out_valid is high and out_ready is low, out_valid and out_data hold.
- R5: In a cycle with no accepted sample, the array does not move and out_data keeps its value. If the output is taken in such a cycle, out_valid falls.
- R6: in_bank is sampled together with the first sample x(i) of each window and selects W[in_bank] for every tap of window i. A bank change between samples never mixes two banks within one output.
- R7: A cycle with wr_en high and in_valid low stores wr_data as W[wr_bank][wr_tap] at the clock edge. Tap index m is the weight that multiplies x(i+m). A cycle with wr_en high and in_valid high leaves every weight unchanged.
- R8: Right after reset, out_valid is low, in_ready is high and out_data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample is offered |
| in_ready | output | 1 | The sample is accepted in this cycle |
| in_data | input | 16 | Signed sample |
| in_bank | input | BANK_W | Weight bank for the window that starts with this sample |
| out_valid | output | 1 | Output register holds an untaken result |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | ACC_W | Signed convolution result |
| wr_en | input | 1 | Weight write request |
| wr_bank | input | BANK_W | Bank of the weight to write |
| wr_tap | input | TAP_W | Tap index of the weight to write |
| wr_data | input | 16 | Signed weight value |

## Verification
The assertions check on every cycle that the output stays quiet while the array fills. They also check that a stalled result holds its value, that the array does not move when no sample is accepted, and that the output drains when it is taken with no new sample behind it. The numeric result of each window needs the bench's reference convolution. So do the bank-switch alignment, the exact width of the sum at extreme operands, and the effect of a weight write attempted during streaming. The bench runs random samples, gaps in the input and output stalls against that reference.

// File: rtl/conv_pkg.sv
package conv_pkg;
  localparam int SAMPLE_W = 16;
  localparam int COEF_W   = 16;
  localparam int PROD_W   = SAMPLE_W + COEF_W;

  typedef logic signed [SAMPLE_W-1:0] sample_t;
  typedef logic signed [COEF_W-1:0]   coef_t;
  typedef logic signed [PROD_W-1:0]   prod_t;

  // Full-precision signed product of one sample and one weight.
  function automatic prod_t mul_s(sample_t a, coef_t b);
    prod_t pa;
    prod_t pb;
    pa = prod_t'(a);
    pb = prod_t'(b);
    return pa * pb;
  endfunction

  // Accumulator width needed for n full-precision products.
  function automatic int acc_width(int n);
    return PROD_W + $clog2(n);
  endfunction
endpackage

// File: rtl/conv_delay_line.sv
// Shift register that advances on step and exposes N_OUT taps.
// Tap j is stage FIRST + STRIDE*j. Stage 0 holds the newest value.
module conv_delay_line #(
  parameter int W      = 16,
  parameter int N_OUT  = 3,
  parameter int FIRST  = 0,
  parameter int STRIDE = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step,
  input  logic [W-1:0]            din,
  output logic [N_OUT-1:0][W-1:0] taps
);
  localparam int DEPTH = FIRST + STRIDE * (N_OUT - 1) + 1;

  logic [DEPTH-1:0][W-1:0] stage;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage <= '0;
    end else if (step) begin
      stage[0] <= din;
      for (int d = 1; d < DEPTH; d++) stage[d] <= stage[d-1];
    end
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_tap
    assign taps[j] = stage[FIRST + STRIDE * j];
  end
endmodule

// File: rtl/conv_cell.sv
// One processing cell: a bank of weights, a registered multiply stage
// and a registered add stage. Both stages advance only on step.
module conv_cell
  import conv_pkg::*;
#(
  parameter int N_BANKS = 2,
  parameter int BANK_W  = 1,
  parameter int ACC_W   = 34
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     step,
  input  sample_t                  x_tap,
  input  logic [BANK_W-1:0]        bank_idx,
  input  logic signed [ACC_W-1:0]  sum_in,
  input  logic                     wr_hit,
  input  logic [BANK_W-1:0]        wr_bank,
  input  coef_t                    wr_val,
  output logic signed [ACC_W-1:0]  sum_out
);
  coef_t coef [N_BANKS];
  prod_t prod_q;
  logic signed [ACC_W-1:0] sum_q;
  logic signed [ACC_W-1:0] prod_ext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < N_BANKS; b++) coef[b] <= '0;
    end else if (wr_hit) begin
      coef[wr_bank] <= wr_val;
    end
  end

  assign prod_ext = ACC_W'(prod_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod_q <= '0;
      sum_q  <= '0;
    end else if (step) begin
      prod_q <= mul_s(x_tap, coef[bank_idx]);
      sum_q  <= sum_in + prod_ext;
    end
  end

  assign sum_out = sum_q;
endmodule

// File: rtl/conv_out_ctrl.sv
// Fill counter and output-valid flag for the result register.
module conv_out_ctrl #(
  parameter int FILL = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic out_ready,
  output logic out_valid,
  output logic filled
);
  localparam int CNT_W = $clog2(FILL + 1);

  logic [CNT_W-1:0] fill_cnt;

  assign filled = (fill_cnt == CNT_W'(FILL));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_cnt  <= '0;
      out_valid <= 1'b0;
    end else if (step) begin
      if (filled) out_valid <= 1'b1;
      else        fill_cnt  <= fill_cnt + 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/conv_array.sv
// Linear systolic convolution array. Cell k holds tap N_TAPS-1-k.
// Samples move two registers per cell, sums one register per cell.
module conv_array
  import conv_pkg::*;
#(
  parameter int N_TAPS  = 3,
  parameter int N_BANKS = 2,
  localparam int BANK_W = (N_BANKS > 1) ? $clog2(N_BANKS) : 1,
  localparam int TAP_W  = (N_TAPS > 1) ? $clog2(N_TAPS) : 1,
  localparam int ACC_W  = acc_width(N_TAPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [15:0]       in_data,
  input  logic [BANK_W-1:0] in_bank,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ACC_W-1:0]  out_data,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] wr_bank,
  input  logic [TAP_W-1:0]  wr_tap,
  input  logic [15:0]       wr_data
);
  // Named internal events, also seen by the checker.
  logic step;
  logic filled;
  logic wr_take;

  logic [N_TAPS-1:0][SAMPLE_W-1:0] x_taps;
  logic [N_TAPS-1:0][BANK_W-1:0]   bank_taps;
  logic signed [ACC_W-1:0]         sum_link [N_TAPS+1];

  assign in_ready = !out_valid || out_ready;
  assign step     = in_valid && in_ready;
  assign wr_take  = wr_en && !in_valid;

  // Sample path: cell k reads stage 2k.
  conv_delay_line #(
    .W(SAMPLE_W), .N_OUT(N_TAPS), .FIRST(0), .STRIDE(2)
  ) u_xline (
    .clk(clk), .rst_n(rst_n), .step(step), .din(in_data), .taps(x_taps)
  );

  // Bank tags: cell k needs the bank of the window's first sample,
  // which is N_TAPS-1+k steps old when cell k multiplies.
  conv_delay_line #(
    .W(BANK_W), .N_OUT(N_TAPS), .FIRST(N_TAPS - 1), .STRIDE(1)
  ) u_bline (
    .clk(clk), .rst_n(rst_n), .step(step), .din(in_bank), .taps(bank_taps)
  );

  assign sum_link[0] = '0;

  for (genvar k = 0; k < N_TAPS; k++) begin : g_cell
    localparam int TAP_OF = N_TAPS - 1 - k;
    logic hit;
    assign hit = wr_take && (wr_tap == TAP_W'(TAP_OF));

    conv_cell #(
      .N_BANKS(N_BANKS), .BANK_W(BANK_W), .ACC_W(ACC_W)
    ) u_cell (
      .clk(clk), .rst_n(rst_n), .step(step),
      .x_tap(sample_t'(x_taps[k])),
      .bank_idx(bank_taps[k]),
      .sum_in(sum_link[k]),
      .wr_hit(hit), .wr_bank(wr_bank), .wr_val(coef_t'(wr_data)),
      .sum_out(sum_link[k+1])
    );
  end

  conv_out_ctrl #(.FILL(2 * N_TAPS)) u_octl (
    .clk(clk), .rst_n(rst_n), .step(step), .out_ready(out_ready),
    .out_valid(out_valid), .filled(filled)
  );

  assign out_data = sum_link[N_TAPS];
endmodule

// File: rtl/conv_array_chk.sv
module conv_array_chk #(
  parameter int ACC_W = 34
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic             out_ready,
  input logic [ACC_W-1:0] out_data,
  input logic             step,
  input logic             filled
);
  // R3: nothing leaves while the chain is still filling
  p_quiet_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !filled |-> !out_valid);

  // R4: a stalled result holds
  p_hold_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R5: no accepted sample, no movement
  p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(out_data));

  // R5: taken with nothing behind it, the output empties
  p_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !step) |=> !out_valid);

  // R2: once filled, each accepted sample yields a result
  p_emit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && filled) |=> out_valid);
endmodule

bind conv_array conv_array_chk #(.ACC_W(ACC_W)) u_conv_array_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .step(step), .filled(filled)
);

// File: tb/test_conv_array.sv
`timescale 1ns/1ps
module test_conv_array;
  localparam int N  = 3;
  localparam int NS = 300;
  localparam int AW = 34;

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0;
  logic in_ready;
  logic [15:0] in_data = '0;
  logic [0:0] in_bank = '0;
  logic out_valid;
  logic out_ready = 1;
  logic [AW-1:0] out_data;
  logic wr_en = 0;
  logic [0:0] wr_bank = '0;
  logic [1:0] wr_tap = '0;
  logic [15:0] wr_data = '0;

  always #2.5 clk = ~clk;

  conv_array i_conv_array (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_bank(in_bank), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .wr_en(wr_en),
    .wr_bank(wr_bank), .wr_tap(wr_tap), .wr_data(wr_data)
  );

  int checks = 0;
  int fails  = 0;
  longint wt [2][N];
  longint xs[$];
  int bs[$];
  longint expq[$];
  string tagq[$];
  int acc_n = 0;
  int got_n = 0;
  bit m_valid = 0;
  bit mon_on = 0;
  bit stall_on = 0;
  bit held_v = 0;
  bit seen_first = 0;
  logic [AW-1:0] held_d;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference model, evaluated between clock edges.
  always @(negedge clk) begin
    if (mon_on) begin
      bit exp_rdy;
      bit nxt;
      exp_rdy = !m_valid || out_ready;
      if (held_v) chk(out_valid && out_data == held_d, "R4",
                      longint'($signed(out_data)), longint'($signed(held_d)));
      chk(out_valid == m_valid, "R5", out_valid, m_valid);
      chk(in_ready == exp_rdy, "R4", in_ready, exp_rdy);
      if (out_valid && !seen_first) begin
        seen_first = 1;
        chk(acc_n == 2*N+1, "R3", acc_n, 2*N+1);
      end
      held_v = out_valid && !out_ready;
      held_d = out_data;
      if (out_valid && out_ready) begin
        if (expq.size() > 0) begin
          longint e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          chk(longint'($signed(out_data)) == e, t, longint'($signed(out_data)), e);
          got_n++;
        end else begin
          chk(0, "R2", longint'($signed(out_data)), 0);
        end
      end
      nxt = m_valid && !out_ready;
      if (in_valid && exp_rdy) begin
        xs.push_back(longint'($signed(in_data)));
        bs.push_back(int'(in_bank));
        if (acc_n >= 2*N) begin
          int i;
          longint y;
          bit mixed;
          bit extreme;
          i = acc_n - 2*N;
          y = 0;
          mixed = 0;
          extreme = 0;
          for (int m = 0; m < N; m++) begin
            y += wt[bs[i]][m] * xs[i+m];
            if (bs[i+m] != bs[i]) mixed = 1;
            if (xs[i+m] == -32768) extreme = 1;
          end
          expq.push_back(y);
          if (mixed)        tagq.push_back("R6");
          else if (extreme) tagq.push_back("R1");
          else if (i >= 200) tagq.push_back("R7");
          else              tagq.push_back("R2");
          nxt = 1;
        end
        acc_n++;
      end
      m_valid = nxt;
    end
  end

  // Random output stalls.
  initial begin
    forever begin
      @(posedge clk);
      #1 out_ready = stall_on ? (($urandom % 4) != 0) : 1'b1;
    end
  end

  task automatic wr_weight(int b, int m, longint v);
    @(posedge clk);
    #1;
    wr_en = 1; wr_bank = 1'(b); wr_tap = 2'(m); wr_data = 16'(v);
    wt[b][m] = v;
    @(posedge clk);
    #1 wr_en = 0;
  endtask

  task automatic send(longint x, int b, bit try_wr);
    int gap;
    gap = $urandom % 3;
    for (int g = 0; g < gap; g++) begin
      @(posedge clk);
      #1 in_valid = 0; wr_en = 0;
    end
    @(posedge clk);
    #1;
    in_valid = 1; in_data = 16'(x); in_bank = 1'(b);
    wr_en = try_wr; wr_bank = 0; wr_tap = 1; wr_data = 16'h3039;
    forever begin
      @(negedge clk);
      if (in_ready) break;
      @(posedge clk);
      #1;
    end
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0, "R8", out_valid, 0);
    chk(in_ready == 1, "R8", in_ready, 1);
    chk(out_data == '0, "R8", longint'($signed(out_data)), 0);
    // R7: weights written while idle
    wr_weight(0, 0, 1200);
    wr_weight(0, 1, -3400);
    wr_weight(0, 2, 250);
    wr_weight(1, 0, -32768);
    wr_weight(1, 1, -32768);
    wr_weight(1, 2, -32768);
    @(posedge clk);
    #1 mon_on = 1; stall_on = 1;
    for (int j = 0; j < NS; j++) begin
      longint x;
      int b;
      b = (j / 37) % 2;
      x = longint'($signed(16'($urandom)));
      if (j >= 150 && j < 170) begin
        b = 1;
        x = (j % 3 == 2) ? 32767 : -32768;
      end
      send(x, b, j == 200);
    end
    @(posedge clk);
    #1 in_valid = 0; wr_en = 0; stall_on = 0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(got_n == NS - 2*N, "R2", got_n, NS - 2*N);
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule